// File: doc/BRIEF.md
# Two-and-a-Half-D Word Store

This block holds 1024 words of 16 bits in flip-flops and gives one combinational read port and one clocked write port that share a single address. It does not decode the address with one flat 10-to-1024 decoder. The ten useful address bits are split in two. The upper five drive a 5-to-32 decoder that enables one row of 32 words. The enabled row places its 32 words onto a shared group bus. Sixteen 32-to-1 multiplexers, one per data bit, then pick the addressed word from that bus using the lower five bits. For a write, a second 5-to-32 decoder selects the column, and only the word where the enabled row and the selected column meet is loaded.

The address port is 16 bits wide so that it matches a 16-bit datapath. The six high bits are not used, so the contents repeat every 1K words. A synchronous active-low reset clears every word to zero. A read of the word being written shows the old contents until the clock edge loads the new value.

Top module: `word_store_2p5d`

## Requirements
- R1: The store holds 1024 independent 16-bit words. After every location has been written with a distinct value, each location reads back its own value.
- R2: On a rising clock edge with `rst_n` low, every word is cleared to 0x0000. This applies at start-up and in the middle of operation.
- R3: On a rising clock edge with `rst_n` high and `wr_en` high, the word at `addr[9:0]` takes the value of `wr_data`.
- R4: When `wr_en` is low, no word changes, whatever `wr_data` and `addr` hold.
- R5: `rd_data` is a combinational function of `addr` and the stored words. It reflects a new address within the same cycle, with no clock edge in between.
- R6: While a write to an address is pending, a read of that same address returns the word's previous contents until the clock edge.
- R7: Bits `addr[15:10]` have no effect on reads or writes. Any two addresses that share `addr[9:0]` refer to the same word.
- R8: `addr[9:5]` selects the row and `addr[4:0]` selects the word within the row. A write leaves untouched the words that differ from the target only in the row bits or only in the column bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset that clears all words |
| addr | input | 16 | Word address; bits [9:5] select the row, bits [4:0] the column, bits [15:10] are unused |
| wr_data | input | 16 | Data to be written |
| wr_en | input | 1 | Write enable, active high |
| rd_data | output | 16 | Contents of the addressed word, combinational |

## Verification
The clocked assertions assume that `addr`, `wr_en` and `wr_data` are known (not X) whenever reset is released. They also assume that these inputs change only between clock edges, so that the value sampled at an edge is the value the write used. The bench meets both conditions. It holds every input at a defined value from time zero, including during reset. It changes inputs one nanosecond after a rising edge and compares read data on the falling edge. For the write-then-read property, the bench writes to an address and then keeps or changes the address in the next cycle, which exercises both the stable-address case and the moving-address case.

// File: rtl/word_store_pkg.sv
// Package: default sizes shared by the word store and its bench.
// Assumes a power-of-two row and column count.
package word_store_pkg;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_ADDR_W  = 16;
    localparam int DEF_ROW_SEL = 5;
    localparam int DEF_COL_SEL = 5;
endpackage

// File: rtl/ws_decoder.sv
// Module: ws_decoder
// Turns a binary select into a one-hot enable vector; used both for
// the row decode and for the write column decode.
// Assumes SEL_W is small (5 gives the 5-to-32 limit).
module ws_decoder #(
    parameter int SEL_W = 5,
    localparam int OUT_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel,
    output logic [OUT_N-1:0] onehot
);
    // Drive exactly one output line high for the selected index.
    always_comb begin
        onehot      = '0;
        onehot[sel] = 1'b1;
    end
endmodule

// File: rtl/ws_bit_mux.sv
// Module: ws_bit_mux
// One data bit's column multiplexer: picks one of 2**SEL_W lanes.
// Assumes the lanes carry the same bit of every word of the row on the group bus.
module ws_bit_mux #(
    parameter int SEL_W = 5,
    localparam int IN_N = 1 << SEL_W
) (
    input  logic [IN_N-1:0]  lanes,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    // Select the lane named by the column bits.
    assign y = lanes[sel];
endmodule

// File: rtl/ws_row.sv
// Module: ws_row
// One row of COLS flip-flop words. Writes the word whose column enable is
// high when the row is enabled, and presents all its words, gated by the
// row enable, so that rows can be ORed onto a shared group bus.
// Assumes at most one row enable and one column enable are high.
module ws_row #(
    parameter int COLS   = 32,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         row_en,
    input  logic                         wr_en,
    input  logic [COLS-1:0]              col_en,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [COLS-1:0][DATA_W-1:0]  row_out
);
    logic [COLS-1:0][DATA_W-1:0] cells;

    for (genvar c = 0; c < COLS; c++) begin : g_word
        // Clear on reset, otherwise load this word when row and column meet.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cells[c] <= '0;
            else if (wr_en && row_en && col_en[c])
                cells[c] <= wr_data;
        end
        // Put this word onto the group bus only while the row is enabled.
        assign row_out[c] = row_en ? cells[c] : '0;
    end
endmodule

// File: rtl/word_store_2p5d.sv
// Module: word_store_2p5d
// 1K x 16 flip-flop store with two-and-a-half-D addressing: a row decoder
// enables one row onto the group bus and per-bit column multiplexers pick
// the word. The write column comes from a second small decoder.
// Assumes inputs change away from the rising edge; the high address bits are unused.
module word_store_2p5d
    import word_store_pkg::*;
#(
    parameter int DATA_W  = DEF_DATA_W,
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int ROW_SEL = DEF_ROW_SEL,
    parameter int COL_SEL = DEF_COL_SEL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int ROWS  = 1 << ROW_SEL;
    localparam int COLS  = 1 << COL_SEL;
    localparam int LOW_W = ROW_SEL + COL_SEL;

    logic [ROW_SEL-1:0]               row_sel;
    logic [COL_SEL-1:0]               col_sel;
    logic [ROWS-1:0]                  row_en;
    logic [COLS-1:0]                  col_en;
    logic [ROWS-1:0][COLS-1:0][DATA_W-1:0] row_words;
    logic [COLS-1:0][DATA_W-1:0]      group_bus;
    logic                             unused_hi_addr;

    assign row_sel        = addr[LOW_W-1:COL_SEL];
    assign col_sel        = addr[COL_SEL-1:0];
    assign unused_hi_addr = &{1'b0, addr[ADDR_W-1:LOW_W]};

    ws_decoder #(.SEL_W(ROW_SEL)) i_row_dec (.sel(row_sel), .onehot(row_en));
    ws_decoder #(.SEL_W(COL_SEL)) i_col_dec (.sel(col_sel), .onehot(col_en));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        ws_row #(.COLS(COLS), .DATA_W(DATA_W)) i_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .row_en (row_en[r]),
            .wr_en  (wr_en),
            .col_en (col_en),
            .wr_data(wr_data),
            .row_out(row_words[r])
        );
    end

    // Merge the gated rows onto one group bus (only the enabled row is non-zero).
    always_comb begin
        group_bus = '0;
        for (int r = 0; r < ROWS; r++)
            group_bus = group_bus | row_words[r];
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic [COLS-1:0] lanes;
        for (genvar c = 0; c < COLS; c++) begin : g_lane
            assign lanes[c] = group_bus[c][b];
        end
        ws_bit_mux #(.SEL_W(COL_SEL)) i_mux (.lanes(lanes), .sel(col_sel), .y(rd_data[b]));
    end

    // R8
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(row_en));

    // R8
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(col_en));

    // R2
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rd_data == '0);

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && addr[LOW_W-1:0] == $past(addr[LOW_W-1:0]))
        |-> rd_data == $past(wr_data));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en) && $stable(addr)) |-> $stable(rd_data));
endmodule

// File: tb/test_word_store_2p5d.sv
module test_word_store_2p5d;
    localparam time TCK = 4ns;

    typedef struct {
        logic [15:0] exp;
        logic [15:0] a;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [15:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic [15:0] rd_data;

    logic [15:0] model [1024];
    item_t       sb_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #(TCK/2) clk = ~clk;

    word_store_2p5d i_word_store_2p5d (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .wr_data(wr_data), .wr_en(wr_en), .rd_data(rd_data)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Monitor: on each falling edge, pop one expected item and compare.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (rd_data !== it.exp) begin
                n_bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, rd_data, it.exp);
            end
        end
    end

    task automatic step_in();
        @(posedge clk);
        #1ns;
    endtask

    // Read at address a and push the expected word.
    task automatic rd(input logic [15:0] a, input string tag);
        step_in();
        wr_en = 1'b0;
        addr  = a;
        sb_q.push_back('{exp: model[a[9:0]], a: a, tag: tag});
    endtask

    // Write d to a; during the cycle the old word must still be visible (R6).
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        step_in();
        wr_en   = 1'b1;
        addr    = a;
        wr_data = d;
        sb_q.push_back('{exp: model[a[9:0]], a: a, tag: "R6"});
        model[a[9:0]] = d;
    endtask

    task automatic do_reset();
        step_in();
        wr_en = 1'b0;
        rst_n = 1'b0;
        step_in();
        step_in();
        rst_n = 1'b1;
        for (int i = 0; i < 1024; i++) model[i] = '0;
    endtask

    initial begin
        #(200000 * TCK);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) model[i] = '0;
        repeat (3) step_in();
        rst_n = 1'b1;

        // R2: reset state
        rd(16'h0000, "R2");
        rd(16'h03FF, "R2");
        rd(16'h0155, "R2");

        // R3 and R8: single write, neighbours in the same row and column untouched
        wr(16'h0123, 16'hBEEF);
        rd(16'h0123, "R3");
        rd(16'h0122, "R8");
        rd(16'h0103, "R8");
        rd(16'h0023, "R8");

        // R4: wr_en low with other data and address present
        step_in();
        wr_en = 1'b0; addr = 16'h0123; wr_data = 16'h1111;
        step_in();
        addr = 16'h0200; wr_data = 16'h2222;
        rd(16'h0123, "R4");
        rd(16'h0200, "R4");

        // R5: address changes with no clock edge between reads
        wr(16'h0040, 16'hA5A5);
        wr(16'h0041, 16'h5A5A);
        step_in();
        wr_en = 1'b0; addr = 16'h0040;
        #0.5ns;
        n_cmp++;
        if (rd_data !== 16'hA5A5) begin
            n_bad++;
            $display("FAIL R5 actual=%h expected=%h", rd_data, 16'hA5A5);
        end
        addr = 16'h0041;
        #0.5ns;
        n_cmp++;
        if (rd_data !== 16'h5A5A) begin
            n_bad++;
            $display("FAIL R5 actual=%h expected=%h", rd_data, 16'h5A5A);
        end

        // R7: high address bits ignored on read and write
        rd(16'hFC40, "R7");
        rd(16'h8441, "R7");
        wr(16'hFC05, 16'h7E57);
        rd(16'h0005, "R7");
        rd(16'h2C05, "R7");

        // R1: fill every location with a distinct value, then read all back
        for (int i = 0; i < 1024; i++)
            wr(16'(i), 16'(i) ^ {6'(i), 10'h2A5});
        for (int i = 0; i < 1024; i++)
            rd(16'(i), "R1");

        // R2: reset in mid-run clears the stored words
        do_reset();
        rd(16'h0000, "R2");
        rd(16'h0123, "R2");
        rd(16'h03FF, "R2");

        repeat (3) step_in();
        finish_run();
    end
endmodule